// File: doc/BRIEF.md
# ULPI Transceiver Register Access Bridge

This block lets a processor read and write the internal registers of an external ULPI transceiver. The processor sees three byte-wide registers: a data byte, a target address byte and a control byte. It loads the address, and the data byte for a write, then sets a request bit in the control byte. The bridge turns this into a ULPI immediate register write or read on the 8-bit PHY bus. It then raises a completion flag that stays set until software clears it. A read result lands in the data register.

Everything runs on the 60 MHz ULPI clock with a synchronous active-high reset. Software may ask for transceiver low-power mode through an input. The bridge overrides that request while an access is pending or running, so the PHY is awake for the access. A cycle limit guarantees that completion appears even when the PHY never acknowledges. Software that gives up after a fixed number of polls therefore never sees a bridge that stays stuck.

Top module: `ulpi_regbridge`

## Requirements
- R1: The CPU registers sit at byte offsets 0x74 (data), 0x75 (target address) and 0x76 (control). Control bit 0 is the request, bit 1 the completion flag and bit 2 the read select (1 = read). Control bits 7:3 read as 0, any other offset reads 0x00, and all registers are 0 after reset.
- R2: A write access puts the command byte {2'b10, addr[5:0]} on the bus and holds it until nxt is high. In the next cycle it drives the data byte. In the cycle after that it drives stp high for exactly one cycle with the bus at 0x00, and then the bus idles at 0x00.
- R3: A read access puts the command byte {2'b11, addr[5:0]} on the bus until nxt. One turnaround cycle follows, then the bridge captures ulpi_data_i into the data register. Completion sets on the first cycle after that in which dir is low.
- R4: The completion flag is sticky. Only a control-register write with bit 1 at 0 clears it.
- R5: Bit 0 of the control register reads 1 from the write that sets it until the transaction begins, and 0 afterwards.
- R6: While a request is pending or a transaction runs, writes to the data, address and control registers are ignored. This includes new requests.
- R7: If dir is high when a request begins, no command is driven until dir is low.
- R8: If dir rises while the command is on the bus, the command is dropped and driven again once dir is low.
- R9: If a transaction is not finished after TIMEOUT_CYC cycles, the bridge returns the bus to idle and sets completion.
- R10: phy_suspend_o equals susp_req_i, except that it is 0 while a request is pending or a transaction runs.
- R11: After reset the bus drives 0x00, stp is low and the link drives the bus (ulpi_data_oe high) whenever dir is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 8 | CPU register byte offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| susp_req_i | input | 1 | Software request for PHY low-power mode |
| phy_suspend_o | output | 1 | Low-power request passed to the PHY |
| ulpi_dir | input | 1 | PHY owns the data bus when high |
| ulpi_nxt | input | 1 | PHY throttle and acknowledge |
| ulpi_data_i | input | 8 | Data bus from the PHY |
| ulpi_data_o | output | 8 | Data bus to the PHY |
| ulpi_data_oe | output | 1 | Link drives the data bus |
| ulpi_stp | output | 1 | Stop strobe to the PHY |

## Verification
The bench holds the command over several cycles without nxt. A bridge that released the command early or skipped ahead would show the data byte too soon. It raises dir both before a request and during the command phase. A bridge that drove into a PHY-owned bus, or that went on without a fresh command, fails the bus-byte checks. It issues requests and address writes during a busy transaction, which would corrupt the address or start a second command if not ignored. It leaves nxt low to force the timeout: a missing limit leaves completion at zero. It also checks that completion survives idle cycles until it is cleared explicitly.

// File: rtl/ulpi_regbridge_pkg.sv
package ulpi_regbridge_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OFF_DATA = 8'h74;
    localparam logic [BYTE_W-1:0] OFF_ADDR = 8'h75;
    localparam logic [BYTE_W-1:0] OFF_CTRL = 8'h76;

    localparam int CB_REQ  = 0;
    localparam int CB_DONE = 1;
    localparam int CB_RD   = 2;

    localparam logic [1:0] CMD_REGWR = 2'b10;
    localparam logic [1:0] CMD_REGRD = 2'b11;

    localparam logic [BYTE_W-1:0] BUS_IDLE = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAITDIR,
        ST_CMD,
        ST_WDATA,
        ST_STP,
        ST_RTURN,
        ST_RCAP,
        ST_REND
    } seq_state_e;

    function automatic logic [BYTE_W-1:0] make_cmd(input logic rd, input logic [BYTE_W-1:0] addr);
        return {(rd ? CMD_REGRD : CMD_REGWR), addr[5:0]};
    endfunction

endpackage

// File: rtl/ulpi_regbridge_csr.sv
module ulpi_regbridge_csr
    import ulpi_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [BYTE_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              seq_busy,
    input  logic              seq_start,
    input  logic              seq_finish,
    input  logic              cap_valid,
    input  logic [BYTE_W-1:0] cap_data,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_data,
    output logic              req_pend,
    output logic              rd_sel,
    output logic              done
);

    logic accept;
    logic ctrl_wr;

    assign accept  = !(req_pend || seq_busy);
    assign ctrl_wr = cpu_we && (cpu_addr == OFF_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr <= '0;
            reg_data <= '0;
            req_pend <= 1'b0;
            rd_sel   <= 1'b0;
        end else begin
            if (seq_start) begin
                req_pend <= 1'b0;
            end
            if (cap_valid) begin
                reg_data <= cap_data;
            end
            if (cpu_we && accept) begin
                unique case (cpu_addr)
                    OFF_DATA: reg_data <= cpu_wdata;
                    OFF_ADDR: reg_addr <= cpu_wdata;
                    OFF_CTRL: begin
                        if (cpu_wdata[CB_REQ]) begin
                            req_pend <= 1'b1;
                            rd_sel   <= cpu_wdata[CB_RD];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else if (seq_finish) begin
            done <= 1'b1;
        end else if (ctrl_wr && !cpu_wdata[CB_DONE]) begin
            done <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            OFF_DATA: cpu_rdata = reg_data;
            OFF_ADDR: cpu_rdata = reg_addr;
            OFF_CTRL: begin
                cpu_rdata[CB_REQ]  = req_pend;
                cpu_rdata[CB_DONE] = done;
                cpu_rdata[CB_RD]   = rd_sel;
            end
            default: cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ulpi_regbridge_timer.sv
module ulpi_regbridge_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == LAST);

endmodule

// File: rtl/ulpi_regbridge_seq.sv
module ulpi_regbridge_seq
    import ulpi_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_pend,
    input  logic              rd_sel,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_data,
    input  logic              ulpi_dir,
    input  logic              ulpi_nxt,
    input  logic [BYTE_W-1:0] ulpi_data_i,
    input  logic              tmo_hit,
    output logic              seq_start,
    output logic              seq_busy,
    output logic              seq_finish,
    output logic              cap_valid,
    output logic [BYTE_W-1:0] cap_data,
    output logic [BYTE_W-1:0] bus_o,
    output logic              stp_o
);

    seq_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx      = st;
        seq_start  = 1'b0;
        seq_finish = 1'b0;
        cap_valid  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_pend) begin
                    seq_start = 1'b1;
                    st_nx     = ulpi_dir ? ST_WAITDIR : ST_CMD;
                end
            end
            ST_WAITDIR: begin
                if (!ulpi_dir) st_nx = ST_CMD;
            end
            ST_CMD: begin
                if (ulpi_dir) begin
                    st_nx = ST_WAITDIR;
                end else if (ulpi_nxt) begin
                    st_nx = rd_sel ? ST_RTURN : ST_WDATA;
                end
            end
            ST_WDATA: st_nx = ST_STP;
            ST_STP: begin
                seq_finish = 1'b1;
                st_nx      = ST_IDLE;
            end
            ST_RTURN: st_nx = ST_RCAP;
            ST_RCAP: begin
                cap_valid = 1'b1;
                st_nx     = ST_REND;
            end
            ST_REND: begin
                if (!ulpi_dir) begin
                    seq_finish = 1'b1;
                    st_nx      = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
        if (st != ST_IDLE && tmo_hit) begin
            st_nx      = ST_IDLE;
            seq_finish = 1'b1;
            cap_valid  = 1'b0;
        end
    end

    always_comb begin
        unique case (st)
            ST_CMD:   bus_o = make_cmd(rd_sel, reg_addr);
            ST_WDATA: bus_o = reg_data;
            default:  bus_o = BUS_IDLE;
        endcase
    end

    assign seq_busy = (st != ST_IDLE);
    assign stp_o    = (st == ST_STP);
    assign cap_data = ulpi_data_i;

endmodule

// File: rtl/ulpi_regbridge.sv
module ulpi_regbridge
    import ulpi_regbridge_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_we,
    input  logic [7:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       susp_req_i,
    output logic       phy_suspend_o,
    input  logic       ulpi_dir,
    input  logic       ulpi_nxt,
    input  logic [7:0] ulpi_data_i,
    output logic [7:0] ulpi_data_o,
    output logic       ulpi_data_oe,
    output logic       ulpi_stp
);

    logic              seq_busy, seq_start, seq_finish, cap_valid, tmo_hit;
    logic              req_pend, rd_sel, done;
    logic [BYTE_W-1:0] cap_data, reg_addr, reg_data;

    ulpi_regbridge_csr csr_i (
        .clk        (clk),
        .rst        (rst),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .seq_busy   (seq_busy),
        .seq_start  (seq_start),
        .seq_finish (seq_finish),
        .cap_valid  (cap_valid),
        .cap_data   (cap_data),
        .reg_addr   (reg_addr),
        .reg_data   (reg_data),
        .req_pend   (req_pend),
        .rd_sel     (rd_sel),
        .done       (done)
    );

    ulpi_regbridge_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .req_pend    (req_pend),
        .rd_sel      (rd_sel),
        .reg_addr    (reg_addr),
        .reg_data    (reg_data),
        .ulpi_dir    (ulpi_dir),
        .ulpi_nxt    (ulpi_nxt),
        .ulpi_data_i (ulpi_data_i),
        .tmo_hit     (tmo_hit),
        .seq_start   (seq_start),
        .seq_busy    (seq_busy),
        .seq_finish  (seq_finish),
        .cap_valid   (cap_valid),
        .cap_data    (cap_data),
        .bus_o       (ulpi_data_o),
        .stp_o       (ulpi_stp)
    );

    ulpi_regbridge_timer #(.LIMIT(TIMEOUT_CYC)) tmr_i (
        .clk (clk),
        .rst (rst),
        .run (seq_busy),
        .hit (tmo_hit)
    );

    assign ulpi_data_oe  = !ulpi_dir;
    assign phy_suspend_o = susp_req_i && !(req_pend || seq_busy);

endmodule

// File: rtl/ulpi_regbridge_chk.sv
module ulpi_regbridge_chk #(
    parameter int TIMEOUT_CYC = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       cpu_we,
    input logic [7:0] cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic       phy_suspend_o,
    input logic       ulpi_stp,
    input logic [7:0] ulpi_data_o,
    input logic       req_pend,
    input logic       seq_busy,
    input logic       done,
    input logic [7:0] reg_addr
);

    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !seq_busy) busy_len <= '0;
        else                  busy_len <= busy_len + 1;
    end

    assert_stp_single_R2: assert property (@(posedge clk) disable iff (rst)
        ulpi_stp |=> (!ulpi_stp && ulpi_data_o == 8'h00));

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !(cpu_we && cpu_addr == 8'h76 && !cpu_wdata[1])) |=> done);

    assert_busy_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 8'h75 && (req_pend || seq_busy)) |=> $stable(reg_addr));

    assert_bounded_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy_len <= 32'(TIMEOUT_CYC));

    assert_wake_on_req_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 8'h76 && cpu_wdata[0] && !req_pend && !seq_busy) |=> !phy_suspend_o);

endmodule

bind ulpi_regbridge ulpi_regbridge_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .phy_suspend_o (phy_suspend_o),
    .ulpi_stp      (ulpi_stp),
    .ulpi_data_o   (ulpi_data_o),
    .req_pend      (req_pend),
    .seq_busy      (seq_busy),
    .done          (done),
    .reg_addr      (reg_addr)
);

// File: tb/ulpi_regbridge_tb_top.sv
module ulpi_regbridge_tb_top;

    localparam logic [7:0] A_DATA = 8'h74;
    localparam logic [7:0] A_ADDR = 8'h75;
    localparam logic [7:0] A_CTRL = 8'h76;
    localparam int NVEC = 4;
    // {rd[20], hold[19:16], addr[15:8], value[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 4'd0, 8'h05, 8'hA5},
        {1'b1, 4'd2, 8'h3F, 8'h5C},
        {1'b0, 4'd3, 8'hC7, 8'h81},
        {1'b1, 4'd0, 8'h12, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_we = 1'b0;
    logic [7:0] cpu_addr = 8'h00, cpu_wdata = 8'h00, cpu_rdata;
    logic susp_req_i = 1'b1, phy_suspend_o;
    logic ulpi_dir = 1'b0, ulpi_nxt = 1'b0;
    logic [7:0] ulpi_data_i = 8'h00, ulpi_data_o;
    logic ulpi_data_oe, ulpi_stp;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ulpi_regbridge dut_i (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .susp_req_i(susp_req_i),
        .phy_suspend_o(phy_suspend_o), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
        .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
        .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    // called just after a negedge; returns 1ns after the next posedge
    task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_we = 1'b0;
    endtask

    logic [7:0] v;

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1/R11 reset state
        rd_reg(A_DATA, v); chk("R1 data reset", v, 8'h00);
        rd_reg(A_ADDR, v); chk("R1 addr reset", v, 8'h00);
        rd_reg(A_CTRL, v); chk("R1 ctrl reset", v, 8'h00);
        chk("R11 bus idle", ulpi_data_o, 8'h00);
        chk("R11 stp low", ulpi_stp, 1'b0);
        chk("R11 oe", ulpi_data_oe, 1'b1);
        chk("R10 suspend follows", phy_suspend_o, 1'b1);
        cpu_wr(8'h10, 8'h77);
        @(negedge clk);
        rd_reg(8'h10, v); chk("R1 unmapped", v, 8'h00);

        // table walk: R2, R3
        for (int i = 0; i < NVEC; i++) begin
            logic isrd;
            logic [3:0] hold;
            logic [7:0] ad, val;
            {isrd, hold, ad, val} = VEC[i];
            cpu_wr(A_ADDR, ad);
            @(negedge clk);
            if (!isrd) begin
                cpu_wr(A_DATA, val);
                @(negedge clk);
            end
            cpu_wr(A_CTRL, isrd ? 8'h05 : 8'h01);
            @(negedge clk);
            chk("R10 suspend held off", phy_suspend_o, 1'b0);
            @(negedge clk);
            for (int h = 0; h <= int'(hold); h++) begin
                chk(isrd ? "R3 cmd byte" : "R2 cmd byte", ulpi_data_o,
                    {isrd ? 2'b11 : 2'b10, ad[5:0]});
                if (h < int'(hold)) @(negedge clk);
            end
            ulpi_nxt = 1'b1;
            @(negedge clk);
            if (!isrd) begin
                chk("R2 data byte", ulpi_data_o, val);
                ulpi_nxt = 1'b0;
                @(negedge clk);
                chk("R2 stp", ulpi_stp, 1'b1);
                chk("R2 stp bus", ulpi_data_o, 8'h00);
                @(negedge clk);
                chk("R2 stp one cycle", ulpi_stp, 1'b0);
                rd_reg(A_CTRL, v); chk("R2 done", v, 8'h02);
                rd_reg(A_DATA, v); chk("R2 data kept", v, val);
            end else begin
                ulpi_nxt = 1'b0; ulpi_dir = 1'b1;
                @(negedge clk);
                ulpi_data_i = val;
                @(negedge clk);
                ulpi_data_i = 8'h00;
                rd_reg(A_CTRL, v); chk("R3 no done while dir", v, 8'h04);
                ulpi_dir = 1'b0;
                @(negedge clk);
                rd_reg(A_CTRL, v); chk("R3 done", v, 8'h06);
                rd_reg(A_DATA, v); chk("R3 read data", v, val);
            end
            chk("R10 suspend released", phy_suspend_o, 1'b1);
            repeat (5) @(negedge clk);
            rd_reg(A_CTRL, v); chk("R4 done sticky", v[1], 1'b1);
            cpu_wr(A_CTRL, 8'h00);
            @(negedge clk);
            rd_reg(A_CTRL, v); chk("R4 done cleared", v[1], 1'b0);
        end

        // R5/R7/R8: dir high at request, then rise during command
        cpu_wr(A_ADDR, 8'h2B);
        @(negedge clk);
        cpu_wr(A_DATA, 8'h6E);
        ulpi_dir = 1'b1;
        @(negedge clk);
        cpu_wr(A_CTRL, 8'h01);
        @(negedge clk);
        rd_reg(A_CTRL, v); chk("R5 req pending", v[0], 1'b1);
        @(negedge clk);
        rd_reg(A_CTRL, v); chk("R5 req self clear", v[0], 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 no drive while dir", ulpi_data_oe, 1'b0);
        chk("R7 no command", ulpi_data_o, 8'h00);
        ulpi_dir = 1'b0;
        @(negedge clk);
        chk("R7 cmd after dir low", ulpi_data_o, 8'hAB);
        ulpi_dir = 1'b1;
        @(negedge clk);
        chk("R8 cmd dropped", ulpi_data_o, 8'h00);
        ulpi_dir = 1'b0;
        @(negedge clk);
        chk("R8 cmd retried", ulpi_data_o, 8'hAB);
        ulpi_nxt = 1'b1;
        @(negedge clk);
        chk("R8 data after retry", ulpi_data_o, 8'h6E);
        ulpi_nxt = 1'b0;
        @(negedge clk);
        chk("R8 stp", ulpi_stp, 1'b1);
        @(negedge clk);
        cpu_wr(A_CTRL, 8'h00);
        @(negedge clk);

        // R6: writes while busy are ignored
        cpu_wr(A_ADDR, 8'h15);
        @(negedge clk);
        cpu_wr(A_DATA, 8'h33);
        @(negedge clk);
        cpu_wr(A_CTRL, 8'h01);
        @(negedge clk);
        cpu_wr(A_ADDR, 8'h2A);
        cpu_wr(A_DATA, 8'h99);
        cpu_wr(A_CTRL, 8'h05);
        @(negedge clk);
        chk("R6 cmd unchanged", ulpi_data_o, 8'h95);
        ulpi_nxt = 1'b1;
        @(negedge clk);
        chk("R6 data unchanged", ulpi_data_o, 8'h33);
        ulpi_nxt = 1'b0;
        repeat (2) @(negedge clk);
        rd_reg(A_ADDR, v); chk("R6 addr ignored", v, 8'h15);
        rd_reg(A_CTRL, v); chk("R6 request ignored", v, 8'h02);
        repeat (5) @(negedge clk);
        chk("R6 no second command", ulpi_data_o, 8'h00);
        cpu_wr(A_CTRL, 8'h00);
        @(negedge clk);

        // R9: no nxt ever
        cpu_wr(A_CTRL, 8'h01);
        repeat (100) @(negedge clk);
        rd_reg(A_CTRL, v); chk("R9 not done early", v[1], 1'b0);
        chk("R9 cmd held", ulpi_data_o, 8'h95);
        repeat (200) @(negedge clk);
        rd_reg(A_CTRL, v); chk("R9 timeout done", v[1], 1'b1);
        chk("R9 bus idle", ulpi_data_o, 8'h00);
        chk("R10 suspend after timeout", phy_suspend_o, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule